// File: doc/BRIEF.md
# Two-Lane Banked FIFO with Deferred-Write Buffer

This queue accepts up to two new entries and gives back up to two of the oldest entries in every cycle. It has no dual-port memory. Storage is split across four single-port banks, and entry address modulo four selects the bank. In any cycle a bank does exactly one thing: it serves a read, it takes a write, or it stays idle.

Reads always win a bank. When an incoming entry's bank is being read in that cycle, the entry goes into a small deferred-write buffer. From there it is written into its bank as soon as that bank has no read. Entries retire from this buffer in any order, one bank at a time. Slots for new entries are found by a scan that starts at a rotating pointer. A pop whose entry is still in the buffer takes its data directly from the buffer.

Callers present per-lane push valids with one shared ready. Pops are requested with a count, and the data comes back one cycle later on two lanes, each with its own valid.

Top module: `mpbank_fifo`

## Requirements
- R1: After reset the queue is empty, `push_ready` is 1 and `pop_valid` is 00.
- R2: Entries leave in the order they were accepted. Within one cycle, push lane 0 is older than push lane 1, and pop lane 0 returns the older of two entries.
- R3: In one cycle the queue can accept two pushes and serve two pops. A pop only ever returns entries that were accepted in earlier cycles.
- R4: Accepted push lanes are packed together. If only lane 1 is valid, its entry takes the next free position, the same as a lone lane-0 push would.
- R5: `pop_count` is 0, 1, 2 or 3, where 3 is treated as 2. The count actually served is the smaller of that value and the number of stored entries. The served lanes are always the lowest-numbered ones, so `pop_valid` is one of 00, 01 or 11.
- R6: `push_ready` is 1 only while at most DEPTH-2 entries are stored and at least two buffer slots are free. While it is 0, push lanes are ignored.
- R7: Data for a pop request appears on `pop_data`, with `pop_valid` set, in the next cycle. `pop_valid` is 00 after a cycle that served no pop.
- R8: A popped entry returns the value that was pushed, even when its bank write was deferred. This holds whether the entry is in its bank or still in the buffer.
- R9: Each bank performs at most one access per cycle. The priority is a pop read first, then the oldest buffered write for that bank, then an incoming write.
- R10: The deferred-write buffer never receives more entries than it has free slots, and it retires entries out of order, per bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | NPORT | Per-lane push request |
| push_data | input | NPORT*DATA_W | Push data; lane i in bits [i*DATA_W +: DATA_W] |
| push_ready | output | 1 | Shared acceptance for all push lanes |
| pop_count | input | $clog2(NPORT+1) | Number of entries requested this cycle |
| pop_valid | output | NPORT | Per-lane pop data valid, one cycle after the request |
| pop_data | output | NPORT*DATA_W | Pop data; lane 0 is the oldest |

## Verification
Single-lane pushes on each lane separately show whether lane packing is correct. A fill of four entries followed by pushes and pops together makes the incoming writes collide with reads on the same banks. This drives entries through the deferred buffer, and later pops then show whether any of them were lost or reordered. A fill to the ready threshold, followed by a push attempt while not ready and a full drain, shows whether stalled pushes are ignored. Long runs of mixed random push and pop patterns then vary the phase between head and tail. This exercises bank contention at every offset and confirms that the deferred entries are retired out of order.

// File: rtl/mpbank_fifo_pkg.sv
package mpbank_fifo_pkg;
   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_READ    = 2'd1,
      OP_PEND_WR = 2'd2,
      OP_PUSH_WR = 2'd3
   } bank_op_e;
endpackage

// File: rtl/mpbank_fifo_bank.sv
module mpbank_fifo_bank #(
   parameter int DATA_W = 16,
   parameter int ROWS   = 8,
   localparam int RW    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [RW-1:0]     row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [ROWS];

   // single-port cell: one access per cycle, read data registered
   always_ff @(posedge clk) begin
      if (en && we)  mem_q[row] <= wdata;
      if (en && !we) rdata      <= mem_q[row];
   end
endmodule

// File: rtl/mpbank_fifo_arb.sv
module mpbank_fifo_arb
   import mpbank_fifo_pkg::*;
(
   input  logic     rd_req,
   input  logic     pend_req,
   input  logic     push_req,
   output bank_op_e op
);
   always_comb begin
      if (rd_req)        op = OP_READ;
      else if (pend_req) op = OP_PEND_WR;
      else if (push_req) op = OP_PUSH_WR;
      else               op = OP_IDLE;
   end
endmodule

// File: rtl/mpbank_fifo_pend.sv
module mpbank_fifo_pend #(
   parameter int DATA_W = 16,
   parameter int PW     = 6,
   parameter int BW     = 2,
   parameter int NBANK  = 4,
   parameter int NPORT  = 2,
   parameter int NPEND  = 4,
   localparam int IW    = $clog2(NPEND),
   localparam int FW    = $clog2(NPEND + 1),
   localparam int RW    = PW - 1 - BW
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [PW-1:0]                 head,
   input  logic [NPORT-1:0]              alloc_vld,
   input  logic [NPORT-1:0][PW-1:0]      alloc_addr,
   input  logic [NPORT-1:0][DATA_W-1:0]  alloc_data,
   input  logic [NBANK-1:0]              retire,
   input  logic [NPORT-1:0]              look_en,
   input  logic [NPORT-1:0][PW-1:0]      look_addr,
   output logic [NBANK-1:0]              has,
   output logic [NBANK-1:0][RW-1:0]      sel_row,
   output logic [NBANK-1:0][DATA_W-1:0]  sel_data,
   output logic [NPORT-1:0]              look_hit,
   output logic [NPORT-1:0][DATA_W-1:0]  look_data,
   output logic [FW-1:0]                 free_cnt
);
   logic [NPEND-1:0]            vld_q, vld_nx, drop, taken;
   logic [PW-1:0]               addr_q [NPEND];
   logic [DATA_W-1:0]           data_q [NPEND];
   logic [PW-1:0]               age    [NPEND];
   logic [PW-1:0]               best   [NBANK];
   logic [NBANK-1:0][IW-1:0]    sel_idx;
   logic [NPORT-1:0][IW-1:0]    slot;
   logic [NPORT-1:0]            slot_ok;
   logic [IW-1:0]               ptr_q, n_alloc, idx_c;

   assign free_cnt = FW'(NPEND) - FW'($countones(vld_q));

   // oldest held write per bank; age is distance from the queue head
   always_comb begin
      for (int e = 0; e < NPEND; e++) age[e] = addr_q[e] - head;
      for (int b = 0; b < NBANK; b++) begin
         has[b]     = 1'b0;
         sel_idx[b] = '0;
         best[b]    = '1;
         for (int e = 0; e < NPEND; e++) begin
            if (vld_q[e] && addr_q[e][BW-1:0] == BW'(b) &&
                (!has[b] || age[e] < best[b])) begin
               has[b]     = 1'b1;
               sel_idx[b] = IW'(e);
               best[b]    = age[e];
            end
         end
         sel_row[b]  = addr_q[sel_idx[b]][PW-2:BW];
         sel_data[b] = data_q[sel_idx[b]];
      end
   end

   // pops that find their entry here take the data and cancel the write
   always_comb begin
      drop = '0;
      for (int i = 0; i < NPORT; i++) begin
         look_hit[i]  = 1'b0;
         look_data[i] = '0;
         for (int e = 0; e < NPEND; e++) begin
            if (look_en[i] && vld_q[e] && addr_q[e] == look_addr[i]) begin
               look_hit[i]  = 1'b1;
               look_data[i] = data_q[e];
               drop[e]      = 1'b1;
            end
         end
      end
   end

   // slot search starts at a rotating pointer
   always_comb begin
      taken   = '0;
      slot_ok = '0;
      slot    = '0;
      n_alloc = '0;
      idx_c   = '0;
      for (int i = 0; i < NPORT; i++) begin
         for (int k = 0; k < NPEND; k++) begin
            idx_c = ptr_q + IW'(k);
            if (alloc_vld[i] && !slot_ok[i] && !vld_q[idx_c] && !taken[idx_c]) begin
               slot_ok[i]   = 1'b1;
               slot[i]      = idx_c;
               taken[idx_c] = 1'b1;
            end
         end
         if (slot_ok[i]) n_alloc = n_alloc + IW'(1);
      end
      vld_nx = vld_q & ~drop;
      for (int b = 0; b < NBANK; b++)
         if (retire[b]) vld_nx[sel_idx[b]] = 1'b0;
      for (int i = 0; i < NPORT; i++)
         if (slot_ok[i]) vld_nx[slot[i]] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else begin
         vld_q <= vld_nx;
         ptr_q <= ptr_q + n_alloc;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NPORT; i++) begin
         if (slot_ok[i]) begin
            addr_q[slot[i]] <= alloc_addr[i];
            data_q[slot[i]] <= alloc_data[i];
         end
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(alloc_vld) <= int'(free_cnt));
   // R10
   alloc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_vld & ~slot_ok) == '0);
   // R9
   retire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retire & ~has) == '0);
endmodule

// File: rtl/mpbank_fifo.sv
module mpbank_fifo
   import mpbank_fifo_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32,
   parameter int NBANK  = 4,
   parameter int NPORT  = 2,
   parameter int NPEND  = 4,
   localparam int CW    = $clog2(NPORT + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORT-1:0]         push_valid,
   input  logic [NPORT*DATA_W-1:0]  push_data,
   output logic                     push_ready,
   input  logic [CW-1:0]            pop_count,
   output logic [NPORT-1:0]         pop_valid,
   output logic [NPORT*DATA_W-1:0]  pop_data
);
   localparam int AW   = $clog2(DEPTH);
   localparam int PW   = AW + 1;
   localparam int BW   = $clog2(NBANK);
   localparam int RW   = AW - BW;
   localparam int ROWS = DEPTH / NBANK;
   localparam int FW   = $clog2(NPEND + 1);

   if ((1 << AW) != DEPTH)        begin : g_bad_depth  $error("DEPTH must be a power of two"); end
   if ((1 << BW) != NBANK)        begin : g_bad_banks  $error("NBANK must be a power of two"); end
   if (NBANK < 2 * NPORT)         begin : g_few_banks  $error("NBANK must be at least 2*NPORT"); end
   if (DEPTH < 2 * NBANK)         begin : g_shallow    $error("DEPTH must be at least 2*NBANK"); end
   if ((1 << $clog2(NPEND)) != NPEND || NPEND < 2 * NPORT)
                                  begin : g_bad_pend   $error("NPEND must be a power of two >= 2*NPORT"); end

   logic [PW-1:0]                  head_q, tail_q, occ, n_acc, want, lim;
   logic [NPORT-1:0]               acc, grant, defer, look_hit;
   logic [NPORT-1:0][PW-1:0]       wr_addr, rd_addr;
   logic [NPORT-1:0][DATA_W-1:0]   wr_data, look_data, buf_q;
   logic [NPORT-1:0][BW-1:0]       bsel_q;
   logic [NPORT-1:0]               from_buf_q, pop_vld_q;
   logic [FW-1:0]                  pend_free;
   logic [NBANK-1:0]               rd_req, in_req, pend_has, retire, in_taken, bk_en, bk_we;
   logic [NBANK-1:0][RW-1:0]       rd_row, in_row, pend_row, bk_row;
   logic [NBANK-1:0][DATA_W-1:0]   in_dat, pend_data, bk_wd, bk_rd;
   bank_op_e                       op [NBANK];

   // ready depends only on registered state
   always_comb begin
      occ        = tail_q - head_q;
      push_ready = (pend_free >= FW'(NPORT)) && (occ <= PW'(DEPTH - NPORT));
   end

   // lane packing for pushes, clamped grant for pops
   always_comb begin
      n_acc = '0;
      for (int i = 0; i < NPORT; i++) begin
         acc[i]     = push_valid[i] & push_ready;
         wr_addr[i] = tail_q + n_acc;
         wr_data[i] = push_data[i*DATA_W +: DATA_W];
         if (acc[i]) n_acc = n_acc + PW'(1);
      end
      want = (pop_count > CW'(NPORT)) ? PW'(NPORT) : PW'(pop_count);
      lim  = (want < occ) ? want : occ;
      for (int i = 0; i < NPORT; i++) begin
         rd_addr[i] = head_q + PW'(i);
         grant[i]   = PW'(i) < lim;
      end
   end

   // route lane requests to banks
   always_comb begin
      rd_req = '0; rd_row = '0; in_req = '0; in_row = '0; in_dat = '0;
      for (int b = 0; b < NBANK; b++) begin
         for (int i = 0; i < NPORT; i++) begin
            if (grant[i] && rd_addr[i][BW-1:0] == BW'(b)) begin
               rd_req[b] = 1'b1;
               rd_row[b] = rd_addr[i][AW-1:BW];
            end
            if (acc[i] && wr_addr[i][BW-1:0] == BW'(b)) begin
               in_req[b] = 1'b1;
               in_row[b] = wr_addr[i][AW-1:BW];
               in_dat[b] = wr_data[i];
            end
         end
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      mpbank_fifo_arb u_arb (
         .rd_req   (rd_req[b]),
         .pend_req (pend_has[b]),
         .push_req (in_req[b]),
         .op       (op[b])
      );
      mpbank_fifo_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) u_bank (
         .clk   (clk),
         .en    (bk_en[b]),
         .we    (bk_we[b]),
         .row   (bk_row[b]),
         .wdata (bk_wd[b]),
         .rdata (bk_rd[b])
      );
      // R9
      bank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (op[b] == OP_PUSH_WR) |-> (!pend_has[b] && !rd_req[b]));
   end

   always_comb begin
      for (int b = 0; b < NBANK; b++) begin
         bk_en[b]    = op[b] != OP_IDLE;
         bk_we[b]    = (op[b] == OP_PEND_WR) || (op[b] == OP_PUSH_WR);
         retire[b]   = op[b] == OP_PEND_WR;
         in_taken[b] = op[b] == OP_PUSH_WR;
         bk_row[b]   = (op[b] == OP_READ)    ? rd_row[b]   :
                       (op[b] == OP_PEND_WR) ? pend_row[b] : in_row[b];
         bk_wd[b]    = (op[b] == OP_PEND_WR) ? pend_data[b] : in_dat[b];
      end
      for (int i = 0; i < NPORT; i++)
         defer[i] = acc[i] && !in_taken[wr_addr[i][BW-1:0]];
   end

   mpbank_fifo_pend #(
      .DATA_W(DATA_W), .PW(PW), .BW(BW), .NBANK(NBANK), .NPORT(NPORT), .NPEND(NPEND)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .head       (head_q),
      .alloc_vld  (defer),
      .alloc_addr (wr_addr),
      .alloc_data (wr_data),
      .retire     (retire),
      .look_en    (grant),
      .look_addr  (rd_addr),
      .has        (pend_has),
      .sel_row    (pend_row),
      .sel_data   (pend_data),
      .look_hit   (look_hit),
      .look_data  (look_data),
      .free_cnt   (pend_free)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q     <= '0;
         tail_q     <= '0;
         pop_vld_q  <= '0;
         from_buf_q <= '0;
         buf_q      <= '0;
         bsel_q     <= '0;
      end else begin
         head_q     <= head_q + lim;
         tail_q     <= tail_q + n_acc;
         pop_vld_q  <= grant;
         from_buf_q <= look_hit;
         buf_q      <= look_data;
         for (int i = 0; i < NPORT; i++) bsel_q[i] <= rd_addr[i][BW-1:0];
      end
   end

   always_comb begin
      pop_valid = pop_vld_q;
      for (int i = 0; i < NPORT; i++)
         pop_data[i*DATA_W +: DATA_W] = from_buf_q[i] ? buf_q[i] : bk_rd[bsel_q[i]];
   end

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !push_ready |=> tail_q == $past(tail_q));
   // R6
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH));
   // R5
   pop_lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid & (pop_valid + NPORT'(1))) == '0);
endmodule

// File: tb/mpbank_fifo_tb_top.sv
`timescale 1ns/1ps
module mpbank_fifo_tb_top;
   localparam int DW    = 16;
   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  push_valid;
   logic [31:0] push_data;
   logic        push_ready;
   logic [1:0]  pop_count;
   logic [1:0]  pop_valid;
   logic [31:0] pop_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [DW-1:0] model_q [$];

   always #2 clk = ~clk;

   mpbank_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .push_data  (push_data),
      .push_ready (push_ready),
      .pop_count  (pop_count),
      .pop_valid  (pop_valid),
      .pop_data   (pop_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int served(input logic [1:0] pc, input int have);
      int n;
      n = (pc > 2'd2) ? 2 : int'(pc);
      return (n > have) ? have : n;
   endfunction

   // one cycle: drive at negedge, check pop outputs at the following negedge
   task automatic cyc(input logic [1:0] v, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [1:0] pc, input string tag);
      int            n;
      logic          rdy;
      logic [DW-1:0] e0, e1;
      logic [1:0]    em;
      push_valid = v;
      push_data  = {d1, d0};
      pop_count  = pc;
      #1;
      rdy = push_ready;
      if (model_q.size() > DEPTH - 2)
         chk(rdy == 1'b0, {tag, " R6 ready high while nearly full"}, 32'(rdy), 32'd0);
      n  = served(pc, model_q.size());
      e0 = '0;
      e1 = '0;
      if (n > 0) e0 = model_q.pop_front();
      if (n > 1) e1 = model_q.pop_front();
      em = (n == 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
      if (v[0] && rdy) model_q.push_back(d0);
      if (v[1] && rdy) model_q.push_back(d1);
      @(posedge clk);
      @(negedge clk);
      chk(pop_valid == em, {tag, " R5 R7 pop_valid"}, 32'(pop_valid), 32'(em));
      if (n > 0) chk(pop_data[15:0]  == e0, {tag, " R2 R8 lane0"}, 32'(pop_data[15:0]),  32'(e0));
      if (n > 1) chk(pop_data[31:16] == e1, {tag, " R2 R8 lane1"}, 32'(pop_data[31:16]), 32'(e1));
      push_valid = '0;
      pop_count  = '0;
   endtask

   initial begin
      void'($urandom(32'd61327));
      rst_n      = 1'b0;
      push_valid = '0;
      push_data  = '0;
      pop_count  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(pop_valid == 2'b00, "R1 pop_valid after reset", 32'(pop_valid), 32'd0);
      chk(push_ready == 1'b1, "R1 push_ready after reset", 32'(push_ready), 32'd1);
      cyc(2'b00, '0, '0, 2'd2, "R1 R5 pop on empty");

      // lane packing
      cyc(2'b10, 16'hdead, 16'h1111, 2'd0, "R4 lane1 only");
      cyc(2'b01, 16'h2222, 16'hbeef, 2'd0, "R4 lane0 only");
      cyc(2'b00, '0, '0, 2'd2, "R4 packed order");

      // pushes colliding with pops on the same banks
      cyc(2'b11, 16'h0a00, 16'h0a01, 2'd0, "R3 fill");
      cyc(2'b11, 16'h0a02, 16'h0a03, 2'd0, "R3 fill");
      cyc(2'b11, 16'h0b00, 16'h0b01, 2'd2, "R3 R9 two in two out");
      cyc(2'b11, 16'h0b02, 16'h0b03, 2'd2, "R3 R9 two in two out");
      for (int k = 0; k < 8; k++)
         cyc(2'b01, 16'h0c00 + 16'(k), '0, 2'd1, "R8 R10 one in one out");
      while (model_q.size() > 0) cyc(2'b00, '0, '0, 2'd2, "R8 drain");

      // count clamping
      cyc(2'b01, 16'h0d00, '0, 2'd0, "R5 single entry");
      cyc(2'b00, '0, '0, 2'd3, "R5 count 3 with one stored");
      cyc(2'b00, '0, '0, 2'd3, "R5 count 3 on empty");

      // ready threshold and ignored pushes
      for (int k = 0; k < 15; k++)
         cyc(2'b11, 16'h1000 + 16'(2*k), 16'h1001 + 16'(2*k), 2'd0, "R6 fill");
      #1;
      chk(push_ready == 1'b1, "R6 ready with DEPTH-2 stored", 32'(push_ready), 32'd1);
      cyc(2'b01, 16'h0e1e, '0, 2'd0, "R6 fill to DEPTH-1");
      #1;
      chk(push_ready == 1'b0, "R6 ready with DEPTH-1 stored", 32'(push_ready), 32'd0);
      cyc(2'b11, 16'hbad0, 16'hbad1, 2'd0, "R6 push while not ready");
      while (model_q.size() > 0) cyc(2'b00, '0, '0, 2'd2, "R6 drain");
      cyc(2'b00, '0, '0, 2'd2, "R6 nothing left after ignored push");

      // mixed random traffic
      for (int k = 0; k < 4000; k++) begin
         logic [1:0]  rv;
         logic [1:0]  rc;
         logic [31:0] rd;
         rv = 2'($urandom);
         rc = 2'($urandom);
         rd = $urandom;
         if (model_q.size() > 24 && rc == 2'd0) rc = 2'd2;
         cyc(rv, rd[15:0], rd[31:16], rc, "R9 R10 random");
      end
      while (model_q.size() > 0) cyc(2'b00, '0, '0, 2'd2, "R10 final drain");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule